// File: doc/BRIEF.md
# Power State Gate Register

This block keeps the power state of a bus function together with the stored copy of its three access enables: bus mastering, memory decode and I/O decode. Software writes a 32-bit word to the power control register. The two low bits request a new state, and only the full-power state and the powered-down state are accepted. While the function is powered down, the three enables presented to the rest of the interface are held at zero. The programmed copies stay intact, so the enables come back unchanged when full power is restored.

The block has two write strobes: one for the power control register and one for the enable register. Each has its own read view. The block also drives a flag that is high while the function is powered down. The event signalling and data reporting fields of the power word are not implemented and read as zero.

Top module: `pwr_state_gate`

## Requirements
- R1: After a synchronous active-low reset, the state reads 00 (full power), the stored enables read 000, the effective enables are 000 and the powered-down flag is low.
- R2: A power-register write with bits 1:0 = 11 moves the state to 11 (powered down) on the next rising clock edge, and the powered-down flag rises on that same edge.
- R3: While the state is 11, the effective enables output is 000 whatever the stored enables are.
- R4: A power-register write with bits 1:0 = 00 moves the state to 00 on the next edge, and from that edge the effective enables equal the stored enables.
- R5: A power-register write with bits 1:0 = 01 or 10 leaves the state, the effective enables and the flag unchanged, and no error output exists.
- R6: The power-register read value has bits 31:2 at zero for any written data, and bits 1:0 equal the state.
- R7: An enable-register write stores data bits 2:0, including while the state is 11, and the stored value survives a trip to 11 and back to 00. The enable-register read value is the stored bits in 2:0 and zero above.
- R8: Writing 11 while in state 11, or 00 while in state 00, leaves the state and the effective enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_wr | input | 1 | Write strobe for the power control register |
| cmd_wr | input | 1 | Write strobe for the enable register |
| wdata | input | 32 | Write data shared by both registers |
| pm_rdata | output | 32 | Read view of the power control register |
| cmd_rdata | output | 32 | Read view of the stored enables |
| cmd_eff | output | 3 | Effective enables: master, memory, I/O in bits 2:0 |
| powered_down | output | 1 | High while the state is 11 |

## Verification
The hardest case to reach is a change to the stored enables made while the outputs are masked, which then has to show up correctly after the return to full power. The bench covers this with a sweep. For every stored enable pattern, it enters the powered-down state, overwrites the enables with a second pattern while masked, then returns to full power and checks the second pattern. For every state and every requested code, it also checks that the unsupported codes and the repeated codes leave the state unchanged.

// File: rtl/pwr_state_gate.sv
module pwr_state_gate #(
  parameter int DW = 32,
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_wr,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pm_rdata,
  output logic [DW-1:0] cmd_rdata,
  output logic [EW-1:0] cmd_eff,
  output logic          powered_down
);
  localparam logic [1:0] ST_FULL = 2'b00;
  localparam logic [1:0] ST_DOWN = 2'b11;

  logic [1:0]    st_q;
  logic [EW-1:0] en_q;
  logic          req_ok;

  assign req_ok = (wdata[1:0] == ST_FULL) || (wdata[1:0] == ST_DOWN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_FULL;
      en_q <= '0;
    end else begin
      if (pm_wr && req_ok) st_q <= wdata[1:0];
      if (cmd_wr) en_q <= wdata[EW-1:0];
    end
  end

  assign powered_down = (st_q == ST_DOWN);
  assign cmd_eff      = powered_down ? '0 : en_q;
  assign pm_rdata     = {{(DW-2){1'b0}}, st_q};
  assign cmd_rdata    = {{(DW-EW){1'b0}}, en_q};
endmodule

module pwr_state_gate_chk #(
  parameter int DW = 32,
  parameter int EW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pm_wr,
  input logic          cmd_wr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] pm_rdata,
  input logic [DW-1:0] cmd_rdata,
  input logic [EW-1:0] cmd_eff,
  input logic          powered_down
);
  // R3
  masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> cmd_eff == '0);
  // R4
  unmasked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !powered_down |-> cmd_eff == cmd_rdata[EW-1:0]);
  // R5
  unsupported_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_wr && (wdata[1:0] == 2'b01 || wdata[1:0] == 2'b10)) |=> $stable(pm_rdata));
  // R2
  enter_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_wr && wdata[1:0] == 2'b11) |=> powered_down);
  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rdata[DW-1:2] == '0 && (powered_down == (pm_rdata[1:0] == 2'b11)));
  // R7
  stored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_rdata));
endmodule

bind pwr_state_gate pwr_state_gate_chk #(.DW(DW), .EW(EW)) u_chk (.*);

// File: tb/test_pwr_state_gate.sv
module test_pwr_state_gate;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, pm_wr = 0, cmd_wr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] pm_rdata, cmd_rdata;
  logic [2:0] cmd_eff;
  logic powered_down;
  int checks = 0, errors = 0;

  pwr_state_gate i_pwr_state_gate (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic pm_write(input logic [31:0] d);
    pm_wr = 1; wdata = d; tick(); pm_wr = 0;
  endtask

  task automatic en_write(input logic [31:0] d);
    cmd_wr = 1; wdata = d; tick(); cmd_wr = 0;
  endtask

  task automatic check_all(input string req, input logic [1:0] st, input logic [2:0] en);
    chk(req, pm_rdata, {30'b0, st});
    chk(req, cmd_rdata, {29'b0, en});
    chk(req, {31'b0, powered_down}, {31'b0, st == 2'b11});
    chk(req, {29'b0, cmd_eff}, {29'b0, (st == 2'b11) ? 3'b000 : en});
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] st;
    logic [2:0] en;
    #2; tick(); tick();
    rst_n = 1; #1;
    check_all("R1", 2'b00, 3'b000);
    st = 0; en = 0;
    // R2 R3 R4 R7: every stored enable pattern, rewritten while masked
    for (int a = 0; a < 8; a++) begin
      en_write(a); en = a;
      check_all("R4", st, en);
      pm_write(32'hFFFF_FFFF); st = 2'b11;
      check_all("R2", st, en);
      for (int b = 0; b < 8; b++) begin
        en_write({29'h1FFF_FFFF, b[2:0]}); en = b;
        check_all("R3", st, en);
      end
      en_write(7 - a); en = 7 - a;
      pm_write(32'hA5A5_A5A0); st = 2'b00;
      check_all("R7", st, en);
    end
    // R5 R8 R6: every state against every requested code with noisy upper bits
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        pm_write(s ? 32'h3 : 32'h0); st = s ? 2'b11 : 2'b00;
        pm_write({30'h2AAA_5555, c[1:0]});
        if (c == 0 || c == 3) st = c[1:0];
        if (c == 1 || c == 2) check_all("R5", st, en);
        else if (c[1:0] == (s ? 2'b11 : 2'b00)) check_all("R8", st, en);
        else check_all("R6", st, en);
      end
    end
    // R1: reset after activity
    pm_write(3); en_write(5);
    rst_n = 0; tick(); rst_n = 1;
    check_all("R1", 2'b00, 3'b000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule